// File: doc/BRIEF.md
# Transmit Descriptor Completion Engine

The block is the transmit half of a descriptor-driven network DMA, reduced to one module around a small local word memory. Software writes descriptors and frame buffers into that memory through a simple word port. Each descriptor is four 32-bit words: a link to the next descriptor, a command/status word, a byte pointer to the buffer, and a word left for software. Software then loads the descriptor pointer and turns the transmitter on.

The engine reads the descriptor and checks the ownership bit. If the descriptor belongs to the engine, it streams the buffer bytes to a MAC-side byte interface with a valid/ready handshake. It then writes the command/status word back as a single word, with ownership cleared and the completion fields set. A non-zero link moves the engine on to the next descriptor. A zero link, or a descriptor that software still holds, stops it.

An auto-pad option pads short frames with zeros. Lengths the engine cannot handle end in an aborted completion and no frame is sent.

Top module: `txdesc_engine`

## Requirements
- R1: After reset `busy`, `tx_valid` and `tx_irq` are low.
- R2: For an owned descriptor with byte count L (bits 11:0), L bytes are sent starting at the buffer byte address. Byte address a is taken from memory word a/4, lane a%4, and lane 0 is bits 7:0. `tx_last` is high on the final byte only.
- R3: On completion the command/status word becomes: bit 31 (ownership) 0; bits 30:28 unchanged; bit 27 (packet OK) 1; bits 26:16 0; bits 15:0 unchanged.
- R4: A descriptor with bit 31 clear sends no bytes, keeps its command/status word unchanged, and leaves the engine stopped (`busy` low).
- R5: A byte count of 0 or above 1536 sends no bytes. The word is written back with bit 31 at 0, bit 27 at 0 and bit 26 (abort) at 1, and bits 30:28 and 15:0 are kept.
- R6: With `cfg_autopad` high, a frame shorter than 60 bytes is sent as 60 bytes, with zeros after the buffer bytes. With `cfg_autopad` low, exactly L bytes are sent.
- R7: After completion, a non-zero link (byte address) starts the descriptor it points to. A zero link stops the engine and `busy` drops.
- R8: `cmd_off` lets the frame in progress finish and write back, but no further descriptor is fetched. Loading the pointer and pulsing `cmd_on` then restarts processing.
- R9: `cmd_reset` drops `tx_valid` and `busy` on the next cycle, and no write-back takes place for the frame it cut.
- R10: `tx_irq` pulses for exactly one cycle when a descriptor whose bit 29 is set completes, and stays low otherwise.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R12: A software memory write to another word in the same cycle as a status write-back lands, and so does the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_we | input | 1 | Software word write strobe |
| mem_addr | input | AW | Software word address (read and write) |
| mem_wdata | input | 32 | Software write data |
| mem_rdata | output | 32 | Word at `mem_addr` |
| ptr_we | input | 1 | Load descriptor pointer (taken while idle) |
| ptr_wdata | input | 32 | Descriptor byte address, word aligned |
| cmd_on | input | 1 | Enable transmitter |
| cmd_off | input | 1 | Disable after current frame |
| cmd_reset | input | 1 | Abort and return to idle at once |
| cfg_autopad | input | 1 | Pad short frames to 60 bytes |
| tx_valid | output | 1 | Byte valid toward MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | MAC accepts byte |
| busy | output | 1 | Engine enabled or working |
| tx_irq | output | 1 | Completion pulse for descriptors requesting it |

## Verification
Two things can land in the same cycle: the engine's write-back of a command/status word and a software write to the descriptor memory. The bench watches for the last byte of the first frame in a two-descriptor chain to be accepted. It then drives a software write to the next descriptor's software word, timed so that it coincides with the write-back cycle. Afterwards both words are read back: the first descriptor must show its completion status and the software word must hold the new value. Both frames must still reach the byte interface in order.

// File: rtl/txdesc_engine.sv
module txdesc_engine #(
  parameter int DEPTH  = 256,
  parameter int MAXLEN = 1536,
  parameter int MINLEN = 60,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_wdata,
  output logic [31:0]   mem_rdata,
  input  logic          ptr_we,
  input  logic [31:0]   ptr_wdata,
  input  logic          cmd_on,
  input  logic          cmd_off,
  input  logic          cmd_reset,
  input  logic          cfg_autopad,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          busy,
  output logic          tx_irq
);
  localparam logic [11:0] MAXL = 12'(MAXLEN);
  localparam logic [11:0] MINL = 12'(MINLEN);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND, S_WB} st_t;

  logic [31:0] mem [DEPTH];
  st_t         state;
  logic        en_q, abort_q, irq_q;
  logic [AW-1:0] dptr;
  logic [31:0] link_q, cs_q, buf_q;
  logic [11:0] cnt, total;

  wire [AW-1:0] cs_idx  = dptr + AW'(1);
  wire [AW-1:0] buf_idx = dptr + AW'(2);
  wire [31:0]   cs_rd   = mem[cs_idx];
  wire [11:0]   len_rd  = cs_rd[11:0];
  wire          bad_len = (len_rd == 12'd0) || (len_rd > MAXL);

  wire [31:0]   baddr   = buf_q + {20'd0, cnt};
  wire [31:0]   bword   = mem[baddr[AW+1:2]];
  wire [31:0]   bshift  = bword >> {baddr[1:0], 3'b000};
  wire [31:0]   wb_word = {1'b0, cs_q[30:28], ~abort_q, abort_q, 10'd0, cs_q[15:0]};

  assign mem_rdata = mem[mem_addr];
  assign tx_valid  = (state == S_SEND);
  assign tx_data   = (cnt < cs_q[11:0]) ? bshift[7:0] : 8'd0;
  assign tx_last   = tx_valid && (cnt == 12'(total - 12'd1));
  assign busy      = (state != S_IDLE) || en_q;
  assign tx_irq    = irq_q;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (state == S_WB) mem[cs_idx] <= wb_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; en_q <= 1'b0; abort_q <= 1'b0; irq_q <= 1'b0;
      dptr <= '0; link_q <= '0; cs_q <= '0; buf_q <= '0;
      cnt <= '0; total <= '0;
    end else if (cmd_reset) begin
      state <= S_IDLE; en_q <= 1'b0; irq_q <= 1'b0; dptr <= '0; cnt <= '0;
    end else begin
      irq_q <= 1'b0;
      if (cmd_on)  en_q <= 1'b1;
      if (cmd_off) en_q <= 1'b0;
      if (ptr_we && state == S_IDLE) dptr <= ptr_wdata[AW+1:2];
      case (state)
        S_IDLE: if (en_q && !cmd_off) state <= S_FETCH;
        S_FETCH: begin
          link_q <= mem[dptr];
          cs_q   <= cs_rd;
          buf_q  <= mem[buf_idx];
          cnt    <= '0;
          if (!cs_rd[31]) begin
            en_q  <= 1'b0;
            state <= S_IDLE;
          end else if (bad_len) begin
            abort_q <= 1'b1;
            state   <= S_WB;
          end else begin
            abort_q <= 1'b0;
            total   <= (cfg_autopad && len_rd < MINL) ? MINL : len_rd;
            state   <= S_SEND;
          end
        end
        S_SEND: if (tx_ready) begin
          cnt <= cnt + 12'd1;
          if (tx_last) state <= S_WB;
        end
        S_WB: begin
          irq_q <= cs_q[29];
          if (link_q == 32'd0) en_q <= 1'b0;
          else dptr <= link_q[AW+1:2];
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_engine_chk.sv
module txdesc_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_reset,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_last,
  input logic [7:0] tx_data,
  input logic       tx_irq
);
  assert_last_in_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cmd_reset) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!busy && !tx_valid));

  assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);
endmodule

bind txdesc_engine txdesc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .busy(busy),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
  .tx_data(tx_data), .tx_irq(tx_irq)
);

// File: tb/tb_txdesc_engine.sv
`timescale 1ns/1ps
module tb_txdesc_engine;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic mem_we = 0; logic [AW-1:0] mem_addr = '0; logic [31:0] mem_wdata = '0;
  logic [31:0] mem_rdata;
  logic ptr_we = 0; logic [31:0] ptr_wdata = '0;
  logic cmd_on = 0, cmd_off = 0, cmd_reset = 0, cfg_autopad = 0;
  logic tx_valid, tx_last, busy, tx_irq; logic [7:0] tx_data;
  logic tx_ready = 1;

  txdesc_engine dut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0, irq_cnt = 0, raw_cnt = 0;
  bit sb_off = 0; bit ready_toggle = 0;
  logic [8:0] expq[$];
  logic [31:0] shadow [256];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  always @(negedge clk) begin
    if (tx_irq) irq_cnt++;
    if (tx_valid && tx_ready) begin
      raw_cnt++;
      if (!sb_off) begin
        if (expq.size() == 0) chk(0, "R2 extra byte", {23'd0, tx_last, tx_data}, 32'h1ff);
        else begin
          logic [8:0] e; e = expq.pop_front();
          chk({tx_last, tx_data} == e, "R2/R6 byte", {23'd0, tx_last, tx_data}, {23'd0, e});
        end
      end
    end
    tx_ready <= ready_toggle ? ~tx_ready : 1'b1;
  end

  task automatic mw(int widx, logic [31:0] d);
    @(negedge clk); mem_we = 1; mem_addr = AW'(widx); mem_wdata = d;
    shadow[widx] = d;
    @(negedge clk); mem_we = 0;
  endtask

  task automatic rd(int widx, output logic [31:0] d);
    mem_addr = AW'(widx); #1; d = mem_rdata;
  endtask

  task automatic put_desc(int base, logic [31:0] link, logic [31:0] cs, logic [31:0] bufp);
    mw(base/4, link); mw(base/4 + 1, cs); mw(base/4 + 2, bufp);
  endtask

  task automatic expect_frame(int bufp, int len, bit pad);
    int total; total = (pad && len < 60) ? 60 : len;
    for (int i = 0; i < total; i++) begin
      logic [7:0] b; logic [31:0] w; int a;
      a = bufp + i; w = shadow[(a / 4) % 256];
      b = (i < len) ? 8'(w >> (8 * (a % 4))) : 8'd0;
      expq.push_back({(i == total - 1), b});
    end
  endtask

  task automatic start(int ptr);
    @(negedge clk); ptr_we = 1; ptr_wdata = ptr;
    @(negedge clk); ptr_we = 0; cmd_on = 1;
    @(negedge clk); cmd_on = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, "R7 engine stops", {31'd0, busy}, 0);
  endtask

  function automatic logic [31:0] wbv(logic [31:0] cs, bit ab);
    return {1'b0, cs[30:28], ~ab, ab, 10'd0, cs[15:0]};
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r, r2; int irq0, raw0;
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !tx_irq, "R1 reset state", {29'd0, busy, tx_valid, tx_irq}, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) mw(i, 32'h9E3779B9 * (i + 1));

    // R2 R3 R10: single frame, interrupt requested
    put_desc(32'h00, 0, 32'hA000_0011, 32'h100);
    expect_frame(32'h100, 17, 0);
    start(32'h00); wait_done();
    chk(expq.size() == 0, "R2 all bytes sent", expq.size(), 0);
    rd(1, r); chk(r == 32'h2800_0011, "R3 writeback", r, 32'h2800_0011);
    chk(irq_cnt == 1, "R10 irq pulse", irq_cnt, 1);

    // R11: unaligned buffer with stalls, no interrupt
    ready_toggle = 1; irq0 = irq_cnt;
    put_desc(32'h00, 0, 32'h8000_0009, 32'h103);
    expect_frame(32'h103, 9, 0);
    start(32'h00); wait_done(); ready_toggle = 0;
    chk(expq.size() == 0, "R11 stalled frame complete", expq.size(), 0);
    chk(irq_cnt == irq0, "R10 no irq without request", irq_cnt, irq0);

    // R6: autopad on and off
    cfg_autopad = 1;
    put_desc(32'h00, 0, 32'h8000_0005, 32'h140);
    expect_frame(32'h140, 5, 1);
    start(32'h00); wait_done();
    chk(expq.size() == 0, "R6 padded to 60", expq.size(), 0);
    cfg_autopad = 0;
    put_desc(32'h00, 0, 32'h8000_0005, 32'h140);
    expect_frame(32'h140, 5, 0);
    start(32'h00); wait_done();
    chk(expq.size() == 0, "R6 unpadded length", expq.size(), 0);

    // R7 R12: chain with software write landing on the write-back cycle
    put_desc(32'h00, 32'h10, 32'h8000_000C, 32'h180);
    put_desc(32'h10, 0, 32'h8000_0007, 32'h1A0);
    mw(7, 32'h1111_1111);
    expect_frame(32'h180, 12, 0); expect_frame(32'h1A0, 7, 0);
    start(32'h00);
    @(negedge clk);
    while (!(tx_valid && tx_ready && tx_last)) @(negedge clk);
    mw(7, 32'hCAFE_F00D);
    wait_done();
    chk(expq.size() == 0, "R7 chained frames", expq.size(), 0);
    rd(1, r); chk(r == 32'h0800_000C, "R12 writeback kept", r, 32'h0800_000C);
    rd(7, r); chk(r == 32'hCAFE_F00D, "R12 software write kept", r, 32'hCAFE_F00D);
    rd(5, r); chk(r == 32'h0800_0007, "R7 second writeback", r, 32'h0800_0007);

    // R4: not owned
    raw0 = raw_cnt;
    put_desc(32'h00, 0, 32'h0000_000A, 32'h100);
    start(32'h00); wait_done();
    chk(raw_cnt == raw0, "R4 no bytes", raw_cnt, raw0);
    rd(1, r); chk(r == 32'h0000_000A, "R4 word unchanged", r, 32'h0000_000A);

    // R5: zero and oversize length
    put_desc(32'h00, 0, 32'hC000_0000, 32'h100);
    start(32'h00); wait_done();
    rd(1, r); chk(r == wbv(32'hC000_0000, 1), "R5 zero length abort", r, wbv(32'hC000_0000, 1));
    put_desc(32'h00, 0, 32'h8000_0601, 32'h100);
    start(32'h00); wait_done();
    rd(1, r); chk(r == wbv(32'h8000_0601, 1), "R5 oversize abort", r, wbv(32'h8000_0601, 1));
    chk(raw_cnt == raw0, "R5 no bytes", raw_cnt, raw0);

    // R8: stop mid-frame, then restart at next descriptor
    put_desc(32'h00, 32'h20, 32'h8000_001E, 32'h100);
    put_desc(32'h20, 0, 32'h8000_0008, 32'h1C0);
    expect_frame(32'h100, 30, 0);
    start(32'h00);
    repeat (8) @(negedge clk);
    cmd_off = 1; @(negedge clk); cmd_off = 0;
    wait_done();
    chk(expq.size() == 0, "R8 current frame finished", expq.size(), 0);
    rd(9, r); chk(r[31] == 1'b1, "R8 next not fetched", r, 32'h8000_0008);
    expect_frame(32'h1C0, 8, 0);
    start(32'h20); wait_done();
    chk(expq.size() == 0, "R8 restart", expq.size(), 0);

    // R9: reset mid-frame
    sb_off = 1; raw0 = raw_cnt;
    put_desc(32'h00, 0, 32'h8000_0028, 32'h100);
    start(32'h00);
    while (raw_cnt < raw0 + 5) @(negedge clk);
    cmd_reset = 1; @(negedge clk); cmd_reset = 0;
    chk(!tx_valid && !busy, "R9 quiet after reset", {30'd0, tx_valid, busy}, 0);
    raw0 = raw_cnt;
    repeat (6) @(negedge clk);
    chk(raw_cnt == raw0, "R9 no more bytes", raw_cnt, raw0);
    rd(1, r2); chk(r2 == 32'h8000_0028, "R9 no writeback", r2, 32'h8000_0028);
    sb_off = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule